// File: doc/BRIEF.md
# Reset-Loaded Security Configuration Register

This block holds the device's security configuration byte. Software can read it and cannot change it. When reset is released, a small sequencer issues a single read of the configuration word from the nonvolatile array. It waits for the array to return the word, then latches one byte lane of it into the register. If the array reports an uncorrectable error with the word, the register is filled with all ones instead, and the device stays secured with backdoor access disabled.

Two decoded outputs are derived from the latched byte. The first tells whether backdoor key access is permitted. The second tells whether the device is secured. Key comparison is done elsewhere and reports success with a one-cycle pulse. When backdoor access is permitted and the fetch has completed, that pulse overwrites the security field with the open code. Every other bit stays as fetched until the next reset.

Top module: `seccfg_reg`

## Requirements
- R1: After reset is released the block raises `fl_req` for exactly one cycle, with `fl_addr` equal to `CFG_ADDR` (default 0x7FFF0F). It raises no further request until the next reset.
- R2: When `fl_valid` is high and `fl_dbl_err` is low, the register takes byte lane `BYTE_SEL` of `fl_data`. In the default configuration this is `fl_data[7:0]`.
- R3: When `fl_valid` and `fl_dbl_err` are both high, the register becomes 8'hFF, whatever the data.
- R4: `ready` rises in the cycle after the word is accepted and stays high until reset.
- R5: A cycle with `bus_rd` high returns the register on `bus_rdata` in the same cycle. `bus_wr` and `bus_wdata` never change the register.
- R6: From reset until `ready` rises, reads return 8'hFF, `secured` is 1 and `key_enabled` is 0.
- R7: Once ready, `key_enabled` is 1 exactly when register bits [7:6] equal 2'b10. The codes 00, 01 and 11 disable it.
- R8: Once ready, `secured` is 0 exactly when register bits [1:0] equal 2'b10. Any other code reports secured.
- R9: An `unlock_ok` pulse while `ready` and `key_enabled` are both high sets bits [1:0] to 2'b10 at the next edge and leaves bits [7:2] unchanged. The forced value holds until reset.
- R10: An `unlock_ok` pulse is ignored while `ready` is low or backdoor access is disabled.
- R11: Bits [5:2] read back exactly as fetched and do not affect `key_enabled` or `secured`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fl_req | output | 1 | Read request to the nonvolatile array |
| fl_addr | output | ADDR_W | Address of the configuration word |
| fl_valid | input | 1 | Array read data valid |
| fl_data | input | DATA_W | Array read word |
| fl_dbl_err | input | 1 | Uncorrectable error flag for the returned word |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (has no effect) |
| bus_wdata | input | 8 | Write data (has no effect) |
| bus_rdata | output | 8 | Read data, zero when not reading |
| unlock_ok | input | 1 | Pulse reporting a successful backdoor key match |
| ready | output | 1 | Fetch complete |
| key_enabled | output | 1 | Backdoor key access permitted |
| secured | output | 1 | Device secured |

## Verification
The assertions assume that the array answers the request exactly once and only after the request cycle. They assume that `fl_dbl_err` is meaningful only while `fl_valid` is high. They also assume that `unlock_ok` arrives as an isolated pulse. The bench models the array by waiting for the request to end, then asserting `fl_valid` once after a chosen latency of zero or more cycles. It drives unlock pulses both before the fetch completes and after, and under enabled and disabled key codes. Each scenario starts from a fresh reset, so every single-fetch window begins clean.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2,
      FS_DONE = 2'd3
   } fetch_state_e;

   typedef struct packed {
      logic [1:0] key;
      logic [3:0] rsv;
      logic [1:0] sec;
   } cfg_t;

   localparam logic [1:0] KEY_OPEN  = 2'b10;
   localparam logic [1:0] SEC_OPEN  = 2'b10;
   localparam logic [7:0] CFG_FAULT = 8'hFF;

endpackage

// File: rtl/seccfg_fetch.sv
module seccfg_fetch
   import seccfg_pkg::*;
#(
   parameter int              ADDR_W   = 24,
   parameter int              DATA_W   = 16,
   parameter int              BYTE_SEL = 0,
   parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fl_req,
   output logic [ADDR_W-1:0] fl_addr,
   input  logic              fl_valid,
   input  logic [DATA_W-1:0] fl_data,
   input  logic              fl_dbl_err,
   output logic              load,
   output cfg_t              load_val,
   output logic              ready
);

   localparam int LANES = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("seccfg_fetch: DATA_W must be a nonzero multiple of 8");
      end
      if (BYTE_SEL < 0 || BYTE_SEL >= LANES) begin : g_bad_lane
         $error("seccfg_fetch: BYTE_SEL outside the word");
      end
   endgenerate

   fetch_state_e state_q, state_d;
   logic [7:0]   lane;

   generate
      if (LANES == 1) begin : g_single_lane
         assign lane = fl_data[7:0];
      end else begin : g_multi_lane
         assign lane = fl_data[BYTE_SEL*8 +: 8];
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_IDLE: state_d = FS_REQ;
         FS_REQ:  state_d = FS_WAIT;
         FS_WAIT: if (fl_valid) state_d = FS_DONE;
         FS_DONE: state_d = FS_DONE;
         default: state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FS_IDLE;
      else        state_q <= state_d;
   end

   assign fl_req   = (state_q == FS_REQ);
   assign fl_addr  = fl_req ? CFG_ADDR : '0;
   assign load     = (state_q == FS_WAIT) && fl_valid;
   assign load_val = fl_dbl_err ? cfg_t'(CFG_FAULT) : cfg_t'(lane);
   assign ready    = (state_q == FS_DONE);

endmodule

// File: rtl/seccfg_store.sv
module seccfg_store
   import seccfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  cfg_t load_val,
   input  logic ready,
   input  logic unlock_ok,
   output cfg_t cfg_q
);

   logic open_hit;

   assign open_hit = ready && unlock_ok && (cfg_q.key == KEY_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= cfg_t'(CFG_FAULT);
      end else if (load) begin
         cfg_q <= load_val;
      end else if (open_hit) begin
         cfg_q.sec <= SEC_OPEN;
      end
   end

endmodule

// File: rtl/seccfg_decode.sv
module seccfg_decode
   import seccfg_pkg::*;
(
   input  logic ready,
   input  cfg_t cfg,
   output logic key_enabled,
   output logic secured
);

   assign key_enabled = ready && (cfg.key == KEY_OPEN);
   assign secured     = !(ready && (cfg.sec == SEC_OPEN));

endmodule

// File: rtl/seccfg_reg.sv
module seccfg_reg
   import seccfg_pkg::*;
#(
   parameter int                ADDR_W    = 24,
   parameter int                DATA_W    = 16,
   parameter int                BYTE_SEL  = 0,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 24'h7FFF0F,
   parameter bit                RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fl_req,
   output logic [ADDR_W-1:0] fl_addr,
   input  logic              fl_valid,
   input  logic [DATA_W-1:0] fl_data,
   input  logic              fl_dbl_err,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              unlock_ok,
   output logic              ready,
   output logic              key_enabled,
   output logic              secured
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("seccfg_reg: ADDR_W must be positive");
      end
   endgenerate

   logic load;
   cfg_t load_val;
   cfg_t cfg_q;
   logic wr_unused;

   assign wr_unused = bus_wr ^ (^bus_wdata);

   seccfg_fetch #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BYTE_SEL (BYTE_SEL),
      .CFG_ADDR (CFG_ADDR)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fl_req     (fl_req),
      .fl_addr    (fl_addr),
      .fl_valid   (fl_valid),
      .fl_data    (fl_data),
      .fl_dbl_err (fl_dbl_err),
      .load       (load),
      .load_val   (load_val),
      .ready      (ready)
   );

   seccfg_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (load_val),
      .ready     (ready),
      .unlock_ok (unlock_ok),
      .cfg_q     (cfg_q)
   );

   seccfg_decode u_decode (
      .ready       (ready),
      .cfg         (cfg_q),
      .key_enabled (key_enabled),
      .secured     (secured)
   );

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [7:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= bus_rd ? cfg_q : 8'h00;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? cfg_q : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/seccfg_chk.sv
module seccfg_chk #(
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fl_req,
   input logic [ADDR_W-1:0] fl_addr,
   input logic              ready,
   input logic              key_enabled,
   input logic              secured,
   input logic              unlock_ok,
   input logic [7:0]        cfg
);

   // R1: the request lasts one cycle
   a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req);

   // R1: the request carries the configuration address
   a_r1_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> (fl_addr == CFG_ADDR));

   // R1: no new request once the fetch is done
   a_r1_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !fl_req);

   // R4: ready stays high until reset
   a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R6: safe outputs before the fetch completes
   a_r6_safe_early: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (secured && !key_enabled));

   // R9: a permitted unlock opens the device
   a_r9_unlock_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && key_enabled && unlock_ok) |=> !secured);

   // R9: an unlock leaves the upper six bits alone
   a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && unlock_ok) |=> (cfg[7:2] == $past(cfg[7:2])));

   // R10: the register is frozen after the fetch unless a permitted unlock arrives
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !(key_enabled && unlock_ok)) |=> $stable(cfg));

endmodule

bind seccfg_reg seccfg_chk #(
   .ADDR_W   (ADDR_W),
   .CFG_ADDR (CFG_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fl_req      (fl_req),
   .fl_addr     (fl_addr),
   .ready       (ready),
   .key_enabled (key_enabled),
   .secured     (secured),
   .unlock_ok   (unlock_ok),
   .cfg         (cfg_q)
);

// File: tb/sim_seccfg_reg.sv
`timescale 1ns/1ps
module sim_seccfg_reg;

   localparam int          ADDR_W   = 24;
   localparam int          DATA_W   = 16;
   localparam logic [23:0] CFG_ADDR = 24'h7FFF0F;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fl_req;
   logic [ADDR_W-1:0] fl_addr;
   logic              fl_valid = 1'b0;
   logic [DATA_W-1:0] fl_data = '0;
   logic              fl_dbl_err = 1'b0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              unlock_ok = 1'b0;
   logic              ready;
   logic              key_enabled;
   logic              secured;

   int  n_cmp = 0;
   int  n_bad = 0;
   int  req_cnt = 0;
   bit  done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   seccfg_reg u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .fl_req      (fl_req),
      .fl_addr     (fl_addr),
      .fl_valid    (fl_valid),
      .fl_data     (fl_data),
      .fl_dbl_err  (fl_dbl_err),
      .bus_rd      (bus_rd),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .unlock_ok   (unlock_ok),
      .ready       (ready),
      .key_enabled (key_enabled),
      .secured     (secured)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // driver: push the expected byte, then strobe one read
   task automatic rd(input logic [7:0] expv, input string tag);
      tick();
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      bus_rd = 1'b1;
      tick();
      bus_rd = 1'b0;
   endtask

   // monitor: compare each read against the queue head
   always @(negedge clk) begin
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard underflow", 32'(bus_rdata), 32'h0);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata === e, t, 32'(bus_rdata), 32'(e));
         end
      end
   end

   // request monitor
   always @(negedge clk) begin
      if (rst_n && fl_req) begin
         req_cnt++;
         chk(fl_addr === CFG_ADDR, "R1 request address", 32'(fl_addr), 32'(CFG_ADDR));
      end
   end

   task automatic pulse_unlock();
      tick();
      unlock_ok = 1'b1;
      tick();
      unlock_ok = 1'b0;
   endtask

   task automatic check_decode(input logic [7:0] b, input string tag);
      @(negedge clk);
      chk(key_enabled === (b[7:6] == 2'b10), {tag, " R7 key_enabled"}, 32'(key_enabled), 32'(b[7:6] == 2'b10));
      chk(secured === (b[1:0] != 2'b10), {tag, " R8 secured"}, 32'(secured), 32'(b[1:0] != 2'b10));
   endtask

   // reset, fetch one word, return the expected register value
   task automatic run_fetch(input logic [15:0] word, input bit err, input int lat,
                            input bit early_unlock, output logic [7:0] expv);
      rst_n = 1'b0;
      fl_valid = 1'b0;
      unlock_ok = 1'b0;
      bus_rd = 1'b0;
      req_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready === 1'b0, "R6 ready low after reset", 32'(ready), 32'h0);
      chk(secured === 1'b1, "R6 secured before fetch", 32'(secured), 32'h1);
      chk(key_enabled === 1'b0, "R6 key disabled before fetch", 32'(key_enabled), 32'h0);
      rd(8'hFF, "R6 read before fetch");
      if (early_unlock) pulse_unlock();
      for (int i = 0; i < lat; i++) tick();
      fl_data = word;
      fl_dbl_err = err;
      fl_valid = 1'b1;
      tick();
      fl_valid = 1'b0;
      fl_dbl_err = 1'b0;
      @(negedge clk);
      chk(ready === 1'b1, "R4 ready after accept", 32'(ready), 32'h1);
      chk(req_cnt == 1, "R1 single request", 32'(req_cnt), 32'h1);
      expv = err ? 8'hFF : word[7:0];
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] e;

      // A: key open, security closed; early unlock ignored, late unlock opens
      run_fetch(16'h5ABD, 1'b0, 2, 1'b1, e);
      rd(e, "R2 R10 lane fetch with early unlock");
      check_decode(e, "A");
      tick();
      bus_wr = 1'b1;
      bus_wdata = 8'h00;
      tick();
      bus_wr = 1'b0;
      rd(e, "R5 write ignored");
      pulse_unlock();
      e = {e[7:2], 2'b10};
      rd(e, "R9 unlock forces open code");
      check_decode(e, "A R9");
      pulse_unlock();
      rd(e, "R9 second unlock holds");
      repeat (4) tick();
      chk(req_cnt == 1, "R1 no refetch", 32'(req_cnt), 32'h1);

      // B: key disabled (01); unlock ignored
      run_fetch(16'hC341, 1'b0, 0, 1'b0, e);
      rd(e, "R2 lane fetch zero latency");
      check_decode(e, "B");
      pulse_unlock();
      rd(e, "R10 unlock ignored key 01");
      check_decode(e, "B R10");

      // C: uncorrectable error fills all ones
      run_fetch(16'h0096, 1'b1, 3, 1'b0, e);
      rd(8'hFF, "R3 fault fill");
      check_decode(8'hFF, "C R3");
      pulse_unlock();
      rd(8'hFF, "R10 unlock ignored key 11");

      // D and E: same key/security codes, opposite reserved bits
      run_fetch(16'hFF82, 1'b0, 1, 1'b0, e);
      rd(8'h82, "R11 reserved zeros");
      check_decode(8'h82, "D R11");
      run_fetch(16'h00BE, 1'b0, 1, 1'b0, e);
      rd(8'hBE, "R11 reserved ones");
      check_decode(8'hBE, "E R11");

      // F: key code 11 with open security code
      run_fetch(16'h12EA, 1'b0, 0, 1'b0, e);
      rd(8'hEA, "R2 R8 open with key 11");
      check_decode(8'hEA, "F");

      chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule